// File: doc/BRIEF.md
# Multi-Level Product-Term Programmable Fabric

This block is a small soft programmable logic core. It is built from ordered levels of product-term blocks. Each product-term block is a compact AND/OR array with twelve inputs and three outputs. Inside a block, every product term is the AND of a chosen set of literals, where a literal is an input or its complement. Each block output is the OR of a chosen set of terms, followed by an optional inversion. Each block input is fed by a multiplexer. That multiplexer can reach every primary input and every output of every block in an earlier level. Signals only move forward through the levels, so an unprogrammed fabric cannot form a combinational loop.

The levels shrink geometrically: each level holds a fixed fraction of the blocks in the level before it, and never fewer than one block. Every primary output has its own selector that can pick any output of any block. All behaviour comes from one configuration register. That register is loaded serially, one bit per clock, and its far end is available for readback. The path from the primary inputs to the primary outputs is purely combinational.

Top module: `pt_fabric`

## Requirements
- R1: After a synchronous reset every configuration bit is 0. As a result, `prim_out` is all zeros for any `prim_in` value, and `cfg_out` is 0.
- R2: On a clock edge with `cfg_en` high, the configuration shifts up by one bit, with `cfg_in` entering bit 0. `cfg_out` is the top bit. When `cfg_en` is low, the configuration holds and the function does not change, whatever `cfg_in` does.
- R3: A 2-bit literal field sits in each product term for each block input. Bit 0 includes the input true, and bit 1 includes it complemented. The term is the AND of every included literal.
- R4: A term with no literal included is 0. A term that includes both polarities of the same input is also 0.
- R5: Each block output has one mask bit per term and one polarity bit. The output is the OR of the masked terms, XOR the polarity bit. With an empty mask and polarity 1, the output is constant 1.
- R6: A block-input select value s below N_IN picks primary input s. The value N_IN + 3*b + o picks output o of block b. Blocks are numbered level by level, starting at level 0.
- R7: A block input whose select names a block in its own level or a later level, or a value past the last source, reads 0.
- R8: Primary-output select value 3*b + o picks output o of block b. Any value of 3*NB or above gives 0.
- R9: Level l holds max(1, floor(n(l-1)*ALPHA_NUM/ALPHA_DEN)) blocks, where n(0) = L0_BLOCKS. Every select field is wide enough for the largest level's source count. The chain length is NB*(12*SEL_W + 24*PTERMS + 3*(PTERMS+1)) + N_OUT*OSEL_W. For the bench parameters this is 890 bits.
- R10: Blocks in a later level can combine outputs of earlier blocks, so multi-level functions such as a 4-input parity reach the primary outputs within the same cycle.
- R11: Configuration layout, with block b starting at bit b*BLK_W:
  - Select fields for inputs 0..11 come first, SEL_W bits each.
  - Then come the literal fields, at offset (t*12+i)*2 for term t and input i.
  - Then, for each output o, come PTERMS mask bits followed by its polarity bit.
  - The primary-output selects follow the last block, OSEL_W bits each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Last bit of the configuration chain |
| prim_in | input | N_IN | Primary inputs of the fabric |
| prim_out | output | N_OUT | Primary outputs of the fabric |

## Verification
The bench builds the fabric with four primary inputs, two outputs, two levels, two blocks in the first level and a drop-off of one half. That gives blocks 0 and 1 in level 0 and block 2 in level 1. With nine terms per block, the chain is 890 bits long. This size makes one level reachable and one level unreachable from each level-0 block, which brings both legal and illegal routing selects within reach. It also covers out-of-range output selects, and a two-level parity function that can be checked exhaustively over all 16 input values. The 18-term variant follows the same layout formulas but is not built by this bench.

// File: rtl/pt_fabric_pkg.sv
package pt_fabric_pkg;

    localparam int BLK_INS  = 12;
    localparam int BLK_OUTS = 3;

    // literal selection per (term, input)
    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_BOTH = 2'b11
    } lit_mode_e;

    function automatic int clog_min1(input int n);
        int w;
        w = $clog2(n);
        return (w < 1) ? 1 : w;
    endfunction

    // blocks in level l of a triangular fabric
    function automatic int lvl_size(input int l0, input int num, input int den, input int l);
        int n;
        n = l0;
        for (int k = 0; k < l; k++) begin
            n = (n * num) / den;
            if (n < 1) n = 1;
        end
        return n;
    endfunction

    // global index of the first block of level l
    function automatic int lvl_first(input int l0, input int num, input int den, input int l);
        int s;
        s = 0;
        for (int k = 0; k < l; k++) s += lvl_size(l0, num, den, k);
        return s;
    endfunction

    function automatic int level_of(input int l0, input int num, input int den,
                                    input int nlev, input int b);
        for (int l = 0; l < nlev; l++)
            if (b < lvl_first(l0, num, den, l + 1)) return l;
        return nlev - 1;
    endfunction

endpackage

// File: rtl/pt_cfg_chain.sv
module pt_cfg_chain #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] cfg
);

    always_ff @(posedge clk) begin
        if (rst)      cfg <= '0;
        else if (en)  cfg <= {cfg[W-2:0], din};
    end

    assign dout = cfg[W-1];

    assert_clear_R1: assert property (@(posedge clk) $past(rst) |-> (cfg == '0));
    assert_hold_R2:  assert property (@(posedge clk) disable iff (rst)
                                      !en |=> $stable(cfg));
    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
                                      en |=> (cfg[0] == $past(din)));

endmodule

// File: rtl/pt_route_mux.sv
module pt_route_mux #(
    parameter int N_LEGAL = 4,
    parameter int SEL_W   = 2
) (
    input  logic [N_LEGAL-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    output logic               y
);

    always_comb begin
        y = 1'b0;
        for (int s = 0; s < N_LEGAL; s++)
            if (sel == SEL_W'(s)) y = src[s];
    end

endmodule

// File: rtl/pt_block.sv
module pt_block
    import pt_fabric_pkg::*;
#(
    parameter int PTERMS = 9,
    localparam int TERM_W = PTERMS * 2 * BLK_INS,
    localparam int OUTC_W = BLK_OUTS * (PTERMS + 1)
) (
    input  logic [BLK_INS-1:0]  blk_in,
    input  logic [TERM_W-1:0]   term_cfg,
    input  logic [OUTC_W-1:0]   out_cfg,
    output logic [BLK_OUTS-1:0] blk_out
);

    logic [PTERMS-1:0] terms;

    // AND plane
    always_comb begin
        lit_mode_e m;
        logic      used;
        logic      prod;
        for (int t = 0; t < PTERMS; t++) begin
            used = 1'b0;
            prod = 1'b1;
            for (int i = 0; i < BLK_INS; i++) begin
                m = lit_mode_e'(term_cfg[(t*BLK_INS + i)*2 +: 2]);
                case (m)
                    LIT_TRUE: begin used = 1'b1; prod = prod &  blk_in[i]; end
                    LIT_COMP: begin used = 1'b1; prod = prod & ~blk_in[i]; end
                    LIT_BOTH: begin used = 1'b1; prod = 1'b0;              end
                    default:  ;
                endcase
            end
            terms[t] = used & prod;
        end
    end

    // OR plane with polarity
    generate
        for (genvar o = 0; o < BLK_OUTS; o++) begin : g_or
            localparam int BASE = o * (PTERMS + 1);
            assign blk_out[o] = (|(terms & out_cfg[BASE +: PTERMS])) ^ out_cfg[BASE + PTERMS];
        end
    endgenerate

endmodule

// File: rtl/pt_fabric.sv
module pt_fabric
    import pt_fabric_pkg::*;
#(
    parameter int N_IN      = 8,
    parameter int N_OUT     = 4,
    parameter int N_LEVELS  = 3,
    parameter int L0_BLOCKS = 4,
    parameter int ALPHA_NUM = 1,
    parameter int ALPHA_DEN = 2,
    parameter int PTERMS    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic [N_IN-1:0]  prim_in,
    output logic [N_OUT-1:0] prim_out
);

    localparam int NB        = lvl_first(L0_BLOCKS, ALPHA_NUM, ALPHA_DEN, N_LEVELS);
    localparam int MAX_LEGAL = N_IN + BLK_OUTS * lvl_first(L0_BLOCKS, ALPHA_NUM, ALPHA_DEN, N_LEVELS - 1);
    localparam int SEL_W     = clog_min1(MAX_LEGAL);
    localparam int ROUTE_W   = BLK_INS * SEL_W;
    localparam int TERM_W    = PTERMS * 2 * BLK_INS;
    localparam int OUTC_W    = BLK_OUTS * (PTERMS + 1);
    localparam int BLK_W     = ROUTE_W + TERM_W + OUTC_W;
    localparam int N_BO      = BLK_OUTS * NB;
    localparam int OSEL_W    = clog_min1(N_BO);
    localparam int OSEL_BASE = NB * BLK_W;
    localparam int CFG_W     = OSEL_BASE + N_OUT * OSEL_W;

    logic [CFG_W-1:0] cfg;
    logic [N_BO-1:0]  all_bo;

    pt_cfg_chain #(.W(CFG_W)) u_chain (
        .clk (clk),
        .rst (rst),
        .en  (cfg_en),
        .din (cfg_in),
        .dout(cfg_out),
        .cfg (cfg)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_blk
            localparam int LV    = level_of(L0_BLOCKS, ALPHA_NUM, ALPHA_DEN, N_LEVELS, b);
            localparam int FIRST = lvl_first(L0_BLOCKS, ALPHA_NUM, ALPHA_DEN, LV);
            localparam int LEGAL = N_IN + BLK_OUTS * FIRST;
            localparam int BASE  = b * BLK_W;

            logic [LEGAL-1:0]    avail;
            logic [BLK_INS-1:0]  bin;
            logic [BLK_OUTS-1:0] bo;

            assign avail[N_IN-1:0] = prim_in;
            for (genvar k = 0; k < FIRST; k++) begin : g_src
                assign avail[N_IN + BLK_OUTS*k +: BLK_OUTS] = g_blk[k].bo;
            end

            for (genvar i = 0; i < BLK_INS; i++) begin : g_in
                logic [SEL_W-1:0] sel;
                assign sel = cfg[BASE + i*SEL_W +: SEL_W];

                pt_route_mux #(.N_LEGAL(LEGAL), .SEL_W(SEL_W)) u_mux (
                    .src(avail),
                    .sel(sel),
                    .y  (bin[i])
                );

                assert_fwd_R7: assert property (@(posedge clk) disable iff (rst)
                    (32'(sel) >= LEGAL) |-> (bin[i] == 1'b0));
            end

            pt_block #(.PTERMS(PTERMS)) u_blk (
                .blk_in  (bin),
                .term_cfg(cfg[BASE + ROUTE_W +: TERM_W]),
                .out_cfg (cfg[BASE + ROUTE_W + TERM_W +: OUTC_W]),
                .blk_out (bo)
            );

            assign all_bo[b*BLK_OUTS +: BLK_OUTS] = bo;
        end

        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            logic [OSEL_W-1:0] osel;
            assign osel = cfg[OSEL_BASE + k*OSEL_W +: OSEL_W];

            pt_route_mux #(.N_LEGAL(N_BO), .SEL_W(OSEL_W)) u_omux (
                .src(all_bo),
                .sel(osel),
                .y  (prim_out[k])
            );

            assert_osel_R8: assert property (@(posedge clk) disable iff (rst)
                (32'(osel) >= N_BO) |-> (prim_out[k] == 1'b0));
        end
    endgenerate

    assert_reset_out_R1: assert property (@(posedge clk) $past(rst) |-> (prim_out == '0));

endmodule

// File: tb/pt_fabric_bench.sv
module pt_fabric_bench;

    localparam int N_IN    = 4;
    localparam int N_OUT   = 2;
    localparam int BP      = 9;
    localparam int SEL_W   = 4;
    localparam int ROUTE_W = 12 * SEL_W;
    localparam int TERM_W  = BP * 24;
    localparam int BLK_W   = ROUTE_W + TERM_W + 3 * (BP + 1);
    localparam int OSEL_W  = 4;
    localparam int CFG_W   = 3 * BLK_W + N_OUT * OSEL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_en = 1'b0;
    logic             cfg_in = 1'b0;
    logic             cfg_out;
    logic [N_IN-1:0]  prim_in = '0;
    logic [N_OUT-1:0] prim_out;

    int n_run  = 0;
    int n_fail = 0;
    logic [CFG_W-1:0] img;

    always #10 clk = ~clk;

    pt_fabric #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_LEVELS(2), .L0_BLOCKS(2),
        .ALPHA_NUM(1), .ALPHA_DEN(2), .PTERMS(BP)
    ) u_pt_fabric (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .cfg_out(cfg_out), .prim_in(prim_in), .prim_out(prim_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // configuration image helpers (layout per R11)
    task automatic set_route(input int b, input int i, input int v);
        img[b*BLK_W + i*SEL_W +: SEL_W] = SEL_W'(v);
    endtask
    task automatic set_lit(input int b, input int t, input int i, input int mode);
        img[b*BLK_W + ROUTE_W + (t*12 + i)*2 +: 2] = 2'(mode);
    endtask
    task automatic set_or(input int b, input int o, input int t);
        img[b*BLK_W + ROUTE_W + TERM_W + o*(BP+1) + t] = 1'b1;
    endtask
    task automatic set_pol(input int b, input int o);
        img[b*BLK_W + ROUTE_W + TERM_W + o*(BP+1) + BP] = 1'b1;
    endtask
    task automatic set_osel(input int k, input int v);
        img[3*BLK_W + k*OSEL_W +: OSEL_W] = OSEL_W'(v);
    endtask

    task automatic load();
        cfg_en = 1'b1;
        for (int n = CFG_W - 1; n >= 0; n--) begin
            cfg_in = img[n];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    task automatic apply(input int v);
        prim_in = N_IN'(v);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        img = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cfg_out", int'(cfg_out), 0);
        for (int v = 0; v < 16; v += 5) begin
            apply(v);
            chk("R1 prim_out", int'(prim_out), 0);
        end
    endtask

    task automatic t_and_term();
        do_reset();
        set_route(0, 0, 0);          // R6 primary input 0
        set_route(0, 1, 1);          // R6 primary input 1
        set_lit(0, 0, 0, 1);         // R3 true literal
        set_lit(0, 0, 1, 2);         // R3 complement literal
        set_or(0, 0, 0);
        set_osel(0, 0);
        load();
        for (int v = 0; v < 16; v++) begin
            apply(v);
            chk("R3 and", int'(prim_out[0]), int'(v[0] & ~v[1]));
        end
    endtask

    task automatic t_empty_terms();
        do_reset();
        set_or(0, 0, 0);             // term 0 empty
        set_lit(0, 1, 0, 3);         // term 1 both polarities
        set_or(0, 1, 1);
        set_osel(0, 0);
        set_osel(1, 1);
        load();
        for (int v = 0; v < 16; v += 3) begin
            apply(v);
            chk("R4 empty term", int'(prim_out[0]), 0);
            chk("R4 both literals", int'(prim_out[1]), 0);
        end
    endtask

    task automatic t_or_pol();
        do_reset();
        for (int i = 0; i < 4; i++) set_route(1, i, i);
        set_lit(1, 0, 0, 1); set_lit(1, 0, 1, 1);
        set_lit(1, 1, 2, 1); set_lit(1, 1, 3, 1);
        set_or(1, 0, 0); set_or(1, 0, 1);
        set_or(1, 1, 0); set_or(1, 1, 1); set_pol(1, 1);
        set_osel(0, 3);
        set_osel(1, 4);
        load();
        for (int v = 0; v < 16; v++) begin
            apply(v);
            chk("R5 or", int'(prim_out[0]), int'((v[0] & v[1]) | (v[2] & v[3])));
            chk("R5 polarity", int'(prim_out[1]), int'(~((v[0] & v[1]) | (v[2] & v[3])) & 1));
        end
        // R2: enable low, toggling cfg_in must not change the function
        for (int c = 0; c < 20; c++) begin
            cfg_in = c[0];
            @(negedge clk);
        end
        apply(3);
        chk("R2 hold", int'(prim_out), 1);
        apply(4);
        chk("R2 hold", int'(prim_out), 2);
    endtask

    task automatic xor_block(input int b, input int a0, input int a1);
        set_route(b, 0, a0);
        set_route(b, 1, a1);
        set_lit(b, 0, 0, 1); set_lit(b, 0, 1, 2);
        set_lit(b, 1, 0, 2); set_lit(b, 1, 1, 1);
        set_or(b, 0, 0); set_or(b, 0, 1);
    endtask

    task automatic t_multilevel();
        do_reset();
        xor_block(0, 0, 1);
        xor_block(1, 2, 3);
        xor_block(2, 4, 7);          // R6 block 0 out 0, block 1 out 0
        set_osel(0, 6);
        set_osel(1, 0);
        load();
        for (int v = 0; v < 16; v++) begin
            apply(v);
            chk("R10 parity", int'(prim_out[0]), int'(^v[3:0]));
            chk("R6 level0 xor", int'(prim_out[1]), int'(v[0] ^ v[1]));
        end
    endtask

    task automatic t_forward_only();
        do_reset();
        set_pol(0, 1);               // block 0 out 1 constant 1 (index 5)
        set_route(0, 0, 5);          // own level: illegal
        set_route(0, 1, 15);         // past last source
        set_lit(0, 0, 0, 1);
        set_or(0, 0, 0);
        set_lit(0, 1, 1, 2);
        set_or(0, 2, 1);
        set_osel(0, 0);
        set_osel(1, 2);
        load();
        for (int v = 0; v < 16; v += 7) begin
            apply(v);
            chk("R7 own level reads 0", int'(prim_out[0]), 0);
            chk("R7 beyond reads 0", int'(prim_out[1]), 1);
        end
    endtask

    task automatic t_osel_range();
        do_reset();
        set_pol(0, 0);
        set_osel(0, 9);
        set_osel(1, 15);
        load();
        apply(5);
        chk("R8 osel 9", int'(prim_out[0]), 0);
        chk("R8 osel 15", int'(prim_out[1]), 0);
        img = '0;
        set_pol(0, 0);
        set_osel(0, 0);
        set_osel(1, 8);
        load();
        apply(5);
        chk("R8 osel 0", int'(prim_out[0]), 1);
        chk("R8 osel 8", int'(prim_out[1]), 0);
    endtask

    task automatic t_chain_len();
        do_reset();
        cfg_en = 1'b1;
        cfg_in = 1'b1;
        @(negedge clk);
        cfg_in = 1'b0;
        for (int n = 1; n < CFG_W - 1; n++) @(negedge clk);
        chk("R9 before length", int'(cfg_out), 0);
        @(negedge clk);
        chk("R9 chain length 890", int'(cfg_out), 1);
        @(negedge clk);
        chk("R2 shifted out", int'(cfg_out), 0);
        cfg_en = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        img = '0;
        @(negedge clk);
        t_reset();
        t_and_term();
        t_empty_terms();
        t_or_pol();
        t_multilevel();
        t_forward_only();
        t_osel_range();
        t_chain_len();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule